// File: doc/BRIEF.md
# Receive Header Split Steering Unit

This block sits in a receive path between a packet parser and the buffer write logic. For every byte of an incoming packet it decides whether the byte goes to a small header buffer, to a payload buffer, or to both. It also gives the byte offset inside each buffer. The decision depends on five values: a 3-bit steering mode, the parsed header length, the packet length, the configured header buffer size, and the position of the byte inside the packet.

Bytes arrive one per cycle while `in_valid` is high. Start-of-packet and end-of-packet markers frame each packet. The strobes and offsets are combinational: they belong to the byte presented in the same cycle, and `wr_data` carries that byte. The mode and the three lengths are taken from the start-of-packet beat and kept for the rest of the packet. One cycle after the end-of-packet beat, a status word reports four things: how many bytes went to the header buffer, how many went to the payload buffer, whether a split was made, and whether the header was replicated.

Top module: `hss_steer`

## Requirements
- R1: Mode encodings are 0 legacy, 1 unsplit, 2 split, 3 split with header buffer always used, 4 replicate, and 5 replicate only for large packets. Codes 6 and 7 act as legacy. In modes 0, 1, 6 and 7 every byte goes to the payload buffer at offset equal to its byte index, and the header buffer is never written.
- R2: A header is usable when its length H is nonzero and H does not exceed the header buffer size S. In mode 2 with a usable header, bytes 0..H-1 go only to the header buffer at offsets 0..H-1, and byte H onward goes only to the payload buffer at offsets starting from 0.
- R3: In mode 2 with an unusable header, every byte goes to the payload buffer at its byte index, and the split flag is 0.
- R4: Mode 3 behaves like mode 2 when the header is usable. When it is not, the first min(P, S) bytes (P = packet length) go only to the header buffer, and the rest go only to the payload buffer starting at offset 0.
- R5: In mode 4 with a usable header, every byte goes to the payload buffer at its byte index, and bytes 0..H-1 are also written to the header buffer at offsets 0..H-1. With an unusable header the header buffer is not written.
- R6: Mode 5 replicates as in R5 only when P > S and the header is usable. Otherwise every byte goes only to the payload buffer at its byte index.
- R7: The header buffer offset on any write is always below S.
- R8: In the cycle after an end-of-packet beat, `st_valid` is high for one cycle. The status then reports the header and payload byte counts of that packet, `st_split` (1 when mode 2 or 3 used a usable header), and `st_repl` (1 when replication was done). At all other times `st_valid` is low.
- R9: Mode, header length, packet length and buffer size are sampled on the start-of-packet beat. Changes on these inputs during later beats of the same packet have no effect.
- R10: No strobe is raised in a cycle where `in_valid` is low, and `wr_data` equals `in_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A packet byte is present |
| in_sop | input | 1 | This byte is the first of its packet |
| in_eop | input | 1 | This byte is the last of its packet |
| in_data | input | 8 | Packet byte |
| cfg_mode | input | 3 | Steering mode, sampled at start of packet |
| cfg_hdr_len | input | LEN_W | Parsed header length in bytes |
| cfg_pkt_len | input | LEN_W | Packet length in bytes |
| cfg_hbuf_size | input | LEN_W | Header buffer size in bytes |
| wr_data | output | 8 | Byte to write |
| hb_we | output | 1 | Write this byte to the header buffer |
| hb_off | output | LEN_W | Offset in the header buffer |
| pb_we | output | 1 | Write this byte to the payload buffer |
| pb_off | output | LEN_W | Offset in the payload buffer |
| st_valid | output | 1 | Per-packet status valid |
| st_hdr_cnt | output | LEN_W | Bytes written to the header buffer |
| st_pay_cnt | output | LEN_W | Bytes written to the payload buffer |
| st_split | output | 1 | Header and payload were split |
| st_repl | output | 1 | Header was replicated |

## Verification
The hardest case to reach is a boundary between fallback paths. In this situation the header is unusable by one byte (H = S + 1, or H = 0), while the packet length sits just below, at, or just above the buffer size, so modes 3 and 5 must choose their fallback exactly. The bench reaches it by sweeping all mode codes against every combination of small header lengths, buffer sizes (including zero) and packet lengths. On every beat after the first, it also drives deliberately wrong configuration values, and it inserts idle cycles inside packets. This makes the sampling rule and the idle behaviour show up in the same sweep.

// File: rtl/hss_pkg.sv
// Shared definitions for the header split steering unit.
// Assumes a 3-bit mode field; codes above the last defined one act as legacy.
package hss_pkg;
    typedef enum logic [2:0] {
        MODE_LEGACY   = 3'd0,
        MODE_WHOLE    = 3'd1,
        MODE_SPLIT    = 3'd2,
        MODE_SPLIT_HB = 3'd3,
        MODE_REPL     = 3'd4,
        MODE_REPL_BIG = 3'd5
    } hss_mode_e;
endpackage

// File: rtl/hss_plan.sv
// Per-packet steering plan: from mode and lengths derive how many leading
// bytes go to the header buffer, whether those bytes are replicated into the
// payload buffer, and the split/replicate flags. Purely combinational.
// Assumes lengths are unsigned byte counts.
module hss_plan #(
    parameter int LEN_W = 14
) (
    input  logic [2:0]       mode,
    input  logic [LEN_W-1:0] hdr_len,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic [LEN_W-1:0] hbuf_size,
    output logic [LEN_W-1:0] region,
    output logic             repl,
    output logic             split
);
    import hss_pkg::*;

    logic             hdr_ok;
    logic [LEN_W-1:0] fill_len;

    // Header is usable when nonzero and fits in the header buffer.
    always_comb begin
        hdr_ok   = (hdr_len != '0) && (hdr_len <= hbuf_size);
        fill_len = (pkt_len < hbuf_size) ? pkt_len : hbuf_size;
    end

    // Mode decode into region size and flags.
    always_comb begin
        region = '0;
        repl   = 1'b0;
        split  = 1'b0;
        case (mode)
            MODE_SPLIT: begin
                split  = hdr_ok;
                region = hdr_ok ? hdr_len : '0;
            end
            MODE_SPLIT_HB: begin
                split  = hdr_ok;
                region = hdr_ok ? hdr_len : fill_len;
            end
            MODE_REPL: begin
                repl   = hdr_ok;
                region = hdr_ok ? hdr_len : '0;
            end
            MODE_REPL_BIG: begin
                repl   = hdr_ok && (pkt_len > hbuf_size);
                region = repl ? hdr_len : '0;
            end
            default: begin
                region = '0;
            end
        endcase
    end
endmodule

// File: rtl/hss_route.sv
// Per-byte router: given the packet plan and the byte index, raise the
// header/payload write strobes and compute offsets. Combinational.
// Assumes idx counts bytes from 0 at start of packet.
module hss_route #(
    parameter int LEN_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic [LEN_W-1:0] idx,
    input  logic [LEN_W-1:0] region,
    input  logic             repl,
    output logic             hb_we,
    output logic [LEN_W-1:0] hb_off,
    output logic             pb_we,
    output logic [LEN_W-1:0] pb_off
);
    logic in_hdr;

    // Bytes below the region go to the header buffer; payload gets the rest,
    // or every byte when replicating.
    always_comb begin
        in_hdr = idx < region;
        hb_we  = valid && in_hdr;
        hb_off = idx;
        pb_we  = valid && (repl || !in_hdr);
        pb_off = repl ? idx : (idx - region);
    end

    // R5: a replicated packet keeps every byte in the payload buffer at its index.
    p_repl_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && repl) |-> (pb_we && pb_off == idx));

    // R10: nothing written on an idle cycle.
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (!hb_we && !pb_we));
endmodule

// File: rtl/hss_tally.sv
// Per-packet byte tally and status register. Counts header and payload
// writes over a packet and publishes them one cycle after the end beat.
// Assumes the start beat always precedes the end beat of a packet.
module hss_tally #(
    parameter int LEN_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic             sop,
    input  logic             eop,
    input  logic             hb_we,
    input  logic             pb_we,
    input  logic             split,
    input  logic             repl,
    output logic             st_valid,
    output logic [LEN_W-1:0] st_hdr_cnt,
    output logic [LEN_W-1:0] st_pay_cnt,
    output logic             st_split,
    output logic             st_repl
);
    logic [LEN_W-1:0] hcnt_q, pcnt_q;
    logic [LEN_W-1:0] hcnt_nx, pcnt_nx;

    // Running totals including the current beat; restart at start of packet.
    always_comb begin
        hcnt_nx = (sop ? '0 : hcnt_q) + LEN_W'(hb_we);
        pcnt_nx = (sop ? '0 : pcnt_q) + LEN_W'(pb_we);
    end

    // Accumulate counts and publish status after the last beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt_q     <= '0;
            pcnt_q     <= '0;
            st_valid   <= 1'b0;
            st_hdr_cnt <= '0;
            st_pay_cnt <= '0;
            st_split   <= 1'b0;
            st_repl    <= 1'b0;
        end else begin
            st_valid <= valid && eop;
            if (valid) begin
                hcnt_q <= hcnt_nx;
                pcnt_q <= pcnt_nx;
                if (eop) begin
                    st_hdr_cnt <= hcnt_nx;
                    st_pay_cnt <= pcnt_nx;
                    st_split   <= split;
                    st_repl    <= repl;
                end
            end
        end
    end

    // R8: every packet leaves at least one byte in some buffer.
    p_status_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> ((st_hdr_cnt != '0) || (st_pay_cnt != '0)));
endmodule

// File: rtl/hss_steer.sv
// Top of the receive header split steering unit. Captures the packet
// configuration on the start beat, tracks the byte index, and drives the
// plan, router and tally. Assumes one byte per valid cycle and
// well-formed start/end framing.
module hss_steer #(
    parameter int LEN_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic [7:0]       in_data,
    input  logic [2:0]       cfg_mode,
    input  logic [LEN_W-1:0] cfg_hdr_len,
    input  logic [LEN_W-1:0] cfg_pkt_len,
    input  logic [LEN_W-1:0] cfg_hbuf_size,
    output logic [7:0]       wr_data,
    output logic             hb_we,
    output logic [LEN_W-1:0] hb_off,
    output logic             pb_we,
    output logic [LEN_W-1:0] pb_off,
    output logic             st_valid,
    output logic [LEN_W-1:0] st_hdr_cnt,
    output logic [LEN_W-1:0] st_pay_cnt,
    output logic             st_split,
    output logic             st_repl
);
    logic [2:0]       mode_q, mode_e;
    logic [LEN_W-1:0] hlen_q, plen_q, hsz_q;
    logic [LEN_W-1:0] hlen_e, plen_e, hsz_e;
    logic [LEN_W-1:0] cnt_q, idx;
    logic [LEN_W-1:0] region;
    logic             repl, split;
    logic             sop_beat;

    // Effective configuration: live inputs on the start beat, held copy after.
    always_comb begin
        sop_beat = in_valid && in_sop;
        mode_e   = in_sop ? cfg_mode      : mode_q;
        hlen_e   = in_sop ? cfg_hdr_len   : hlen_q;
        plen_e   = in_sop ? cfg_pkt_len   : plen_q;
        hsz_e    = in_sop ? cfg_hbuf_size : hsz_q;
        idx      = in_sop ? '0 : cnt_q;
        wr_data  = in_data;
    end

    // Hold configuration from the start beat and advance the byte index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            hlen_q <= '0;
            plen_q <= '0;
            hsz_q  <= '0;
            cnt_q  <= '0;
        end else if (in_valid) begin
            if (in_sop) begin
                mode_q <= cfg_mode;
                hlen_q <= cfg_hdr_len;
                plen_q <= cfg_pkt_len;
                hsz_q  <= cfg_hbuf_size;
            end
            cnt_q <= idx + LEN_W'(1);
        end
    end

    hss_plan #(.LEN_W(LEN_W)) u_plan (
        .mode      (mode_e),
        .hdr_len   (hlen_e),
        .pkt_len   (plen_e),
        .hbuf_size (hsz_e),
        .region    (region),
        .repl      (repl),
        .split     (split)
    );

    hss_route #(.LEN_W(LEN_W)) u_route (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (in_valid),
        .idx    (idx),
        .region (region),
        .repl   (repl),
        .hb_we  (hb_we),
        .hb_off (hb_off),
        .pb_we  (pb_we),
        .pb_off (pb_off)
    );

    hss_tally #(.LEN_W(LEN_W)) u_tally (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (in_valid),
        .sop        (in_sop),
        .eop        (in_eop),
        .hb_we      (hb_we),
        .pb_we      (pb_we),
        .split      (split),
        .repl       (repl),
        .st_valid   (st_valid),
        .st_hdr_cnt (st_hdr_cnt),
        .st_pay_cnt (st_pay_cnt),
        .st_split   (st_split),
        .st_repl    (st_repl)
    );

    // R1: legacy-class modes never touch the header buffer.
    p_legacy_no_hdr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (mode_e <= 3'd1 || mode_e >= 3'd6)) |-> !hb_we);

    // R2: plain split mode never sends one byte to both buffers.
    p_split_one_sink_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_e == 3'd2) |-> !(hb_we && pb_we));

    // R7: header buffer writes stay inside the configured size.
    p_hdr_in_bounds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hb_we |-> (hb_off < hsz_e));

    // R9: held mode changes only on a start beat.
    p_mode_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sop_beat |=> $stable(mode_q));
endmodule

// File: tb/sim_hss_steer.sv
module sim_hss_steer;
    localparam int LEN_W = 14;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0]       in_data = '0;
    logic [2:0]       cfg_mode = '0;
    logic [LEN_W-1:0] cfg_hdr_len = '0, cfg_pkt_len = '0, cfg_hbuf_size = '0;
    logic [7:0]       wr_data;
    logic             hb_we, pb_we, st_valid, st_split, st_repl;
    logic [LEN_W-1:0] hb_off, pb_off, st_hdr_cnt, st_pay_cnt;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    hss_steer #(.LEN_W(LEN_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_data(in_data), .cfg_mode(cfg_mode),
        .cfg_hdr_len(cfg_hdr_len), .cfg_pkt_len(cfg_pkt_len),
        .cfg_hbuf_size(cfg_hbuf_size), .wr_data(wr_data), .hb_we(hb_we),
        .hb_off(hb_off), .pb_we(pb_we), .pb_off(pb_off), .st_valid(st_valid),
        .st_hdr_cnt(st_hdr_cnt), .st_pay_cnt(st_pay_cnt),
        .st_split(st_split), .st_repl(st_repl)
    );

    task automatic check(input bit ok, input string req, input string got, input string exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %s expected %s", req, got, exp);
        end
    endtask

    // Drive one packet and compare every beat and the status against the model.
    task automatic send_pkt(input int m, input int h, input int s, input int p);
        int  mm, region, e_h = 0, e_p = 0;
        bit  ok, rep, spl;
        string tag;
        mm  = (m > 5) ? 0 : m;
        ok  = (h != 0) && (h <= s);
        rep = (mm == 4 && ok) || (mm == 5 && ok && p > s);
        spl = (mm == 2 || mm == 3) && ok;
        if (mm == 2) region = ok ? h : 0;
        else if (mm == 3) region = ok ? h : ((p < s) ? p : s);
        else if (rep) region = h;
        else region = 0;
        case (mm)
            0, 1: tag = "R1";
            2: tag = ok ? "R2" : "R3";
            3: tag = "R4";
            4: tag = "R5";
            default: tag = "R6";
        endcase
        for (int i = 0; i < p; i++) begin
            bit xh, xp;
            int xho, xpo;
            if (((i + m + h) % 3) == 2) begin
                @(negedge clk);
                in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
                cfg_mode = 3'(m ^ 7);
                #5;
                check(!hb_we && !pb_we, "R10",
                      $sformatf("hb_we=%0b pb_we=%0b", hb_we, pb_we), "0 0");
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_sop   = (i == 0);
            in_eop   = (i == p - 1);
            in_data  = 8'((i * 37 + m * 5 + h) & 255);
            if (i == 0) begin
                cfg_mode = 3'(m); cfg_hdr_len = LEN_W'(h);
                cfg_pkt_len = LEN_W'(p); cfg_hbuf_size = LEN_W'(s);
            end else begin
                cfg_mode = 3'(m ^ 5); cfg_hdr_len = LEN_W'(h + 3);
                cfg_pkt_len = LEN_W'(0); cfg_hbuf_size = LEN_W'(s + 9);
            end
            xh  = (i < region);
            xho = i;
            xp  = rep || (i >= region);
            xpo = rep ? i : i - region;
            e_h += xh;
            e_p += xp;
            #5;
            check(hb_we == xh && pb_we == xp && (!xh || hb_off == xho) && (!xp || pb_off == xpo),
                  (i > 0) ? {tag, "/R9"} : tag,
                  $sformatf("m%0d h%0d s%0d p%0d i%0d: hb %0b@%0d pb %0b@%0d", m, h, s, p, i,
                            hb_we, hb_off, pb_we, pb_off),
                  $sformatf("hb %0b@%0d pb %0b@%0d", xh, xho, xp, xpo));
            if (hb_we)
                check(hb_off < s, "R7", $sformatf("hb_off=%0d", hb_off), $sformatf("<%0d", s));
            check(wr_data == in_data, "R10", $sformatf("%0h", wr_data), $sformatf("%0h", in_data));
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        #5;
        check(st_valid && st_hdr_cnt == e_h && st_pay_cnt == e_p && st_split == spl && st_repl == rep,
              "R8",
              $sformatf("m%0d h%0d s%0d p%0d: v%0b h%0d p%0d s%0b r%0b", m, h, s, p,
                        st_valid, st_hdr_cnt, st_pay_cnt, st_split, st_repl),
              $sformatf("v1 h%0d p%0d s%0b r%0b", e_h, e_p, spl, rep));
        @(negedge clk);
        #5;
        check(!st_valid, "R8", $sformatf("st_valid=%0b", st_valid), "0");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #5;
        check(!st_valid && !hb_we && !pb_we, "R10",
              $sformatf("st=%0b hb=%0b pb=%0b", st_valid, hb_we, pb_we), "0 0 0");
        for (int m = 0; m < 8; m++)
            for (int h = 0; h < 6; h++)
                for (int s = 0; s < 5; s++)
                    for (int p = 1; p < 7; p++)
                        send_pkt(m, h, s, p);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(20 * 190000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule